// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Binary Counter

This block is a binary counter that can be preset and counts either up or down. It is made of identical 4-bit stages. Each stage has its own register, its own decode of load, enable and direction, and a terminal-count flag gated by its chain enable. Every register changes on the rising clock edge. A parameter sets how many stages are chained to form one wide counter. Each stage's active-low terminal flag drives the chain enable of the stage above it, so no extra logic is needed between stages.

Control inputs:
- An active-low load presets the whole count from a parallel data word on the next edge. Load overrides both enables.
- Counting needs both active-low enables low: the local enable and the chain enable.
- A direction input chooses between increment and decrement.

The output flag is low only when three things hold together: the chain enable is low, the count sits at its terminal value, and the terminal value matches the chosen direction (all ones when counting up, zero when counting down). The flag is decoded from registered state, so it does not glitch while counting.

Top module: `updn_counter_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 on that edge, whatever the load, enable and direction inputs are.
- R2: With `rst_n` high and `load_n` low, the next edge copies `data` into `count`, whatever `en_p_n`, `en_t_n` and `up` are.
- R3: With `load_n` high and either `en_p_n` or `en_t_n` high, `count` keeps its value across the edge.
- R4: With `load_n`, `en_p_n` and `en_t_n` all low and `up` high (1), `count` rises by one per edge and wraps from all ones to 0.
- R5: With `load_n`, `en_p_n` and `en_t_n` all low and `up` low (0), `count` falls by one per edge and wraps from 0 to all ones.
- R6: `carry_n` is low exactly when `en_t_n` is low and `count` is all ones with `up` high, or 0 with `up` low. Otherwise it is high. It does not depend on `en_p_n` or `load_n`.
- R7: The chained stages behave as one counter of STAGES*STAGE_W bits. An upper stage steps on the same edge on which every stage below it wraps, and all bits update on that single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p_n | input | 1 | Active-low count enable shared by every stage |
| en_t_n | input | 1 | Active-low chain enable into the lowest stage; also gates `carry_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| data | input | STAGES*STAGE_W (12) | Parallel preset value |
| count | output | STAGES*STAGE_W (12) | Registered count |
| carry_n | output | 1 | Active-low terminal-count output of the top stage |

## Verification
The count is tried under several input patterns: preset, increment, decrement, and holds from each enable on its own. A hold from the local enable and a hold from the chain enable must both freeze the count. A load while both enables are asserted shows whether load really has priority. Counts placed just under and just over the 0x0FF/0x100 and 0xFFF/0x000 boundaries separate a correct carry between stages from one that is missing or late. The output flag is sampled with the local enable high and with load low, to show that only the chain enable and the direction-matched terminal value control it.

// File: rtl/updn_cnt_pkg.sv
// Package: shared types for the up/down counter stages.
// Assumes: nothing; contains only the per-stage operation encoding.
package updn_cnt_pkg;

    // Operation a stage performs on the next rising clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/updn_op_decode.sv
// Module: updn_op_decode
// Works out what a stage does on the next edge. Load comes first and overrides
// both enables. Otherwise the stage steps in the direction given by `up`
// only when both active-low enables are low, and holds in every other case.
// Assumes: all inputs are synchronous to the stage clock.
module updn_op_decode
    import updn_cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_p_n,
    input  logic    en_t_n,
    input  logic    up,
    output cnt_op_e op
);

    // Select the operation: load, then count, then hold.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (!en_p_n && !en_t_n) begin
            op = up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/updn_tc_decode.sv
// Module: updn_tc_decode
// Active-low terminal-count flag of one stage. The flag is low when the chain
// enable is low and the registered count is at the end of its range for the
// current direction. Because it comes only from state, direction and the chain
// enable, it has no count-time glitches.
// Assumes: q is a registered value.
module updn_tc_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         up,
    input  logic         en_t_n,
    output logic         carry_n
);

    logic at_max;
    logic at_min;

    // Detect the two end-of-range values.
    always_comb begin
        at_max = &q;
        at_min = ~|q;
    end

    // Gate the direction-matched terminal flag with the chain enable.
    always_comb begin
        carry_n = ~(~en_t_n & (up ? at_max : at_min));
    end

endmodule

// File: rtl/updn_stage.sv
// Module: updn_stage
// One W-bit slice of the counter: operation decode, state register with
// next-state logic, and terminal-count decode.
// Assumes: synchronous active-low reset; en_t_n is either the chain input or
// the carry_n output of the stage below.
module updn_stage
    import updn_cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         en_p_n,
    input  logic         en_t_n,
    input  logic         up,
    input  logic [W-1:0] data,
    output logic [W-1:0] q,
    output logic         carry_n
);

    localparam logic [W-1:0] ONE = W'(1);

    cnt_op_e      op;
    logic [W-1:0] q_next;

    updn_op_decode u_op (
        .load_n (load_n),
        .en_p_n (en_p_n),
        .en_t_n (en_t_n),
        .up     (up),
        .op     (op)
    );

    // Form the next count from the selected operation; wrap is natural modulo 2^W.
    always_comb begin
        unique case (op)
            OP_LOAD: q_next = data;
            OP_INC:  q_next = q + ONE;
            OP_DEC:  q_next = q - ONE;
            default: q_next = q;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    updn_tc_decode #(.W(W)) u_tc (
        .q       (q),
        .up      (up),
        .en_t_n  (en_t_n),
        .carry_n (carry_n)
    );

endmodule

// File: rtl/updn_counter_chain.sv
// Module: updn_counter_chain
// Top level: STAGES copies of updn_stage. Each stage's carry_n drives the
// chain enable of the stage above, so the whole chain counts as one
// STAGES*STAGE_W-bit synchronous counter with no gating between stages.
// Assumes: STAGES >= 1, STAGE_W >= 1; synchronous active-low reset.
module updn_counter_chain #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 3,
    localparam int TOTAL_W = STAGE_W * STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic               en_p_n,
    input  logic               en_t_n,
    input  logic               up,
    input  logic [TOTAL_W-1:0] data,
    output logic [TOTAL_W-1:0] count,
    output logic               carry_n
);

    // Chain enables: index 0 is the external input, index k+1 is stage k's flag.
    logic [STAGES:0] t_chain;

    assign t_chain[0] = en_t_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        updn_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_n  (load_n),
            .en_p_n  (en_p_n),
            .en_t_n  (t_chain[k]),
            .up      (up),
            .data    (data[k*STAGE_W +: STAGE_W]),
            .q       (count[k*STAGE_W +: STAGE_W]),
            .carry_n (t_chain[k+1])
        );
    end

    assign carry_n = t_chain[STAGES];

endmodule

// File: rtl/updn_counter_chain_chk.sv
// Module: updn_counter_chain_chk
// Temporal checks on the port behaviour of updn_counter_chain, bound to it below.
// Assumes: rst_n is held low for at least one edge at start-up.
module updn_counter_chain_chk #(
    parameter int TOTAL_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_n,
    input logic               en_p_n,
    input logic               en_t_n,
    input logic               up,
    input logic [TOTAL_W-1:0] data,
    input logic [TOTAL_W-1:0] count,
    input logic               carry_n
);

    logic rst_seen_q = 1'b0;

    // Remember that reset was sampled on the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> (count == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load_n) |=> (count == $past(data)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && load_n && (en_p_n || en_t_n)) |=> $stable(count));

    assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && load_n && !en_p_n && !en_t_n && up)
        |=> (count == $past(count) + TOTAL_W'(1)));

    assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && load_n && !en_p_n && !en_t_n && !up)
        |=> (count == $past(count) - TOTAL_W'(1)));

    assert_carry_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (!en_t_n && (up ? (count == '1) : (count == '0))));

    assert_carry_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_t_n && up && (count == '1)) |-> !carry_n);

endmodule

bind updn_counter_chain updn_counter_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .en_p_n  (en_p_n),
    .en_t_n  (en_t_n),
    .up      (up),
    .data    (data),
    .count   (count),
    .carry_n (carry_n)
);

// File: tb/updn_counter_chain_tb.sv
module updn_counter_chain_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         en_p_n = 1'b1;
    logic         en_t_n = 1'b1;
    logic         up = 1'b1;
    logic [W-1:0] data = '0;
    logic [W-1:0] count;
    logic         carry_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    updn_counter_chain #(.STAGE_W(4), .STAGES(3)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .en_p_n  (en_p_n),
        .en_t_n  (en_t_n),
        .up      (up),
        .data    (data),
        .count   (count),
        .carry_n (carry_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic         ld_n;
        logic         p_n;
        logic         t_n;
        logic         dir;
        logic [W-1:0] din;
        logic [W-1:0] exp_q;
        logic         exp_c;
        logic [2:0]   req;
    } vec_t;

    // req field: requirement number the vector mainly targets.
    localparam vec_t VECS [15] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 12'h0FE, 12'h0FE, 1'b1, 3'd2}, // R2 preset
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h0FF, 1'b1, 3'd4}, // R4 up
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h100, 1'b1, 3'd7}, // R7 carry into stage 2
        '{1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 12'h100, 1'b1, 3'd3}, // R3 hold by P
        '{1'b1, 1'b0, 1'b1, 1'b1, 12'h000, 12'h100, 1'b1, 3'd3}, // R3 hold by T
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'h0FF, 1'b1, 3'd7}, // R7 borrow across stages
        '{1'b0, 1'b0, 1'b0, 1'b1, 12'hFFE, 12'hFFE, 1'b1, 3'd2}, // R2 load beats enables
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b0, 3'd6}, // R6 terminal up
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1, 3'd4}, // R4 wrap up
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b1, 3'd5}, // R5 wrap down
        '{1'b0, 1'b1, 1'b1, 1'b0, 12'h001, 12'h001, 1'b1, 3'd2}, // R2 preset
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b0, 3'd6}, // R6 terminal down
        '{1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'h000, 1'b0, 3'd6}, // R6 flag ignores P
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'hA5C, 12'hA5C, 1'b1, 3'd2}, // R2 preset
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'hA5B, 1'b1, 3'd5}  // R5 down
    };

    task automatic check(input string req, input logic [W-1:0] actual,
                         input logic [W-1:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expected);
        end
    endtask

    task automatic drive(input logic ld, input logic p, input logic t,
                         input logic d, input logic [W-1:0] v);
        load_n = ld;
        en_p_n = p;
        en_t_n = t;
        up     = d;
        data   = v;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    logic [W-1:0] ref_q;

    initial begin
        // R1: reset state with the inputs asking for a load.
        drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h777);
        rst_n = 1'b0;
        repeat (3) step();
        check("R1", count, 12'h000);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        step();
        check("R1", count, 12'h000);

        // Vector table.
        for (int i = 0; i < 15; i++) begin
            drive(VECS[i].ld_n, VECS[i].p_n, VECS[i].t_n, VECS[i].dir, VECS[i].din);
            step();
            check($sformatf("R%0d count vec%0d", VECS[i].req, i), count, VECS[i].exp_q);
            check($sformatf("R6 flag vec%0d", i), {11'd0, carry_n}, {11'd0, VECS[i].exp_c});
        end

        // R7: long up run across both stage boundaries against a reference model.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 12'hFF0);
        step();
        ref_q = 12'hFF0;
        drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
        for (int n = 0; n < 40; n++) begin
            step();
            ref_q = ref_q + 12'd1;
            check("R7 up run", count, ref_q);
        end

        // R7: long down run from 0x103.
        drive(1'b0, 1'b1, 1'b1, 1'b0, 12'h103);
        step();
        ref_q = 12'h103;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        for (int n = 0; n < 24; n++) begin
            step();
            ref_q = ref_q - 12'd1;
            check("R7 down run", count, ref_q);
        end

        // R6: flag ignores load; T high forces it high; wrong direction keeps it high.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFF);
        step();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 12'h123);
        #1;
        check("R6 flag with load low", {11'd0, carry_n}, 12'd0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        #1;
        check("R6 flag with T high", {11'd0, carry_n}, 12'd1);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        #1;
        check("R6 flag all ones counting down", {11'd0, carry_n}, 12'd1);
        step();
        check("R3 hold", count, 12'hFFF);

        // R1: reset in mid-operation while counting.
        drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
        rst_n = 1'b0;
        step();
        check("R1 mid-run", count, 12'h000);
        rst_n = 1'b1;
        step();
        check("R4 after reset", count, 12'h001);

        done = 1'b1;
        finish_run();
    end

endmodule